// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block runs the memory side of a load-multiple or store-multiple instruction. On a start request it decodes the instruction word: the addressing mode (before/after, increasing/decreasing), the writeback and direction bits, the base register number and a register selection mask. It then walks the mask from the lowest register number to the highest. For each selected register it issues one full-word bus access, naming that register on a side output. Stores send the register value the register file returns for that name. Loads hand the returned word back to the register file together with the name.

Whatever the mode, the lowest address is worked out up front from the number of selected registers, and addresses only ever climb by one word per transfer. When the last transfer has been acknowledged, the block raises a one-cycle completion pulse. With that pulse it presents the updated base value and a writeback enable, so the register file can commit the new base. A new instruction is taken only once the block is idle again, which is the cycle after the completion pulse.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset `idle_o` is 1 while `bus_req_o`, `done_o`, `reg_we_o` and `wb_en_o` are 0.
- R2: Instruction fields: bit 24 = before (1) / after (0), bit 23 = increasing (1) / decreasing (0), bit 21 = writeback, bit 20 = load (1) / store (0), bits [19:16] = base register number (driven on `wb_idx_o`), bits [15:0] = register mask (bit k selects register k).
- R3: With N the number of set mask bits, the first access address is base (after/increasing), base+4 (before/increasing), base-4N (before/decreasing) or base-4N+4 (after/decreasing).
- R4: Exactly one access is made per selected register, in ascending register number, and each access address is 4 above the previous one.
- R5: While a request is not acknowledged, `bus_req_o` stays high and the address, write flag and register number stay unchanged.
- R6: A store drives `bus_we_o`=1 with `bus_wdata_o` equal to `reg_rdata_i`. A load drives `bus_we_o`=0, and in the acknowledge cycle it raises `reg_we_o` with `reg_widx_o` = the current register number and `reg_wdata_o` = `bus_rdata_i`.
- R7: `done_o` rises for exactly one cycle, the cycle after the last acknowledge. In that cycle `wb_value_o` is base+4N (increasing) or base-4N (decreasing), and `wb_en_o` equals the writeback bit. `idle_o` is 1 in the next cycle.
- R8: An empty mask makes no bus access. `done_o` follows in the cycle after start, and `wb_value_o` equals the base.
- R9: `start_i` is ignored while `idle_o` is 0. The transfer in progress and its results are unchanged.
- R10: With `bus_ack_i` held high, one access completes per cycle, so `done_o` comes N+1 cycles after the start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| insn_i | input | INSN_W | Instruction word |
| base_i | input | ADDR_W | Base register value |
| idle_o | output | 1 | Ready to accept a start |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 = write (store), 0 = read (load) |
| bus_addr_o | output | ADDR_W | Word access address |
| bus_wdata_o | output | DATA_W | Store data |
| bus_ack_i | input | 1 | Bus acknowledge for the current access |
| bus_rdata_i | input | DATA_W | Load data, valid with acknowledge |
| xfer_idx_o | output | IDX_W | Register number of the current access |
| reg_rdata_i | input | DATA_W | Register file value for `xfer_idx_o` |
| reg_we_o | output | 1 | Register file write strobe for loads |
| reg_widx_o | output | IDX_W | Register number to write |
| reg_wdata_o | output | DATA_W | Word to write |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Base writeback enable, valid with done |
| wb_idx_o | output | 4 | Base register number |
| wb_value_o | output | ADDR_W | Updated base value |

## Verification
The assertions assume that `bus_ack_i` is only meaningful while a request is up, and that the bus eventually acknowledges every request. They also assume that `start_i` may arrive at any time but only counts while idle. The stimulus meets these assumptions: a responder either holds acknowledge high or randomly delays it by a cycle or two, and it computes read data from a word memory that earlier stores have filled. Start pulses are also injected while a transfer is in flight, to show they are ignored.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

   // instruction field positions (decoded by this block)
   localparam int FLD_BEFORE = 24;
   localparam int FLD_UP     = 23;
   localparam int FLD_WBACK  = 21;
   localparam int FLD_LOAD   = 20;
   localparam int FLD_RN_LSB = 16;
   localparam int RN_W       = 4;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_MOVE = 2'd1,
      SQ_FIN  = 2'd2
   } sq_state_e;

endpackage

// File: rtl/blkxfer_popcount.sv
module blkxfer_popcount #(
   parameter int LIST_W = 16,
   parameter int CNT_W  = $clog2(LIST_W + 1),
   parameter int STYLE  = 1
) (
   input  logic [LIST_W-1:0] bits_i,
   output logic [CNT_W-1:0]  count_o
);

   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("blkxfer_popcount: STYLE must be 0 or 1");
   end
   if (STYLE == 1 && (LIST_W % 4) != 0) begin : g_bad_chunk
      $error("blkxfer_popcount: chunked style needs LIST_W multiple of 4");
   end
   if (CNT_W < $clog2(LIST_W + 1)) begin : g_bad_cnt
      $error("blkxfer_popcount: CNT_W too narrow");
   end

   generate
      if (STYLE == 0) begin : g_serial
         always_comb begin
            count_o = '0;
            for (int i = 0; i < LIST_W; i++) begin
               count_o = count_o + CNT_W'(bits_i[i]);
            end
         end
      end else begin : g_chunk
         localparam int NCH = LIST_W / 4;
         logic [2:0] part [NCH];
         for (genvar c = 0; c < NCH; c++) begin : g_part
            assign part[c] = 3'(bits_i[4*c])   + 3'(bits_i[4*c+1])
                           + 3'(bits_i[4*c+2]) + 3'(bits_i[4*c+3]);
         end
         always_comb begin
            count_o = '0;
            for (int c = 0; c < NCH; c++) begin
               count_o = count_o + CNT_W'(part[c]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/blkxfer_lowest.sv
module blkxfer_lowest #(
   parameter int LIST_W = 16,
   parameter int IDX_W  = $clog2(LIST_W)
) (
   input  logic [LIST_W-1:0] mask_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic [LIST_W-1:0] onehot_o
);

   if ((1 << IDX_W) < LIST_W) begin : g_bad_idx
      $error("blkxfer_lowest: IDX_W cannot number every list bit");
   end

   logic [LIST_W:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < LIST_W; i++) begin : g_bit
      assign seen[i+1]   = seen[i] | mask_i[i];
      assign onehot_o[i] = mask_i[i] & ~seen[i];
   end

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < LIST_W; i++) begin
         if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
      end
   end

endmodule

// File: rtl/blkxfer_addrgen.sv
module blkxfer_addrgen #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 5,
   parameter int WORD_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              before_i,
   input  logic              up_i,
   output logic [ADDR_W-1:0] start_o,
   output logic [ADDR_W-1:0] final_o
);

   localparam int SH = $clog2(WORD_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   if ((1 << SH) != WORD_BYTES) begin : g_bad_word
      $error("blkxfer_addrgen: WORD_BYTES must be a power of two");
   end

   logic [ADDR_W-1:0] span;
   assign span = ADDR_W'(count_i) << SH;

   // lowest address touched, for every mode
   always_comb begin
      unique case ({before_i, up_i})
         2'b01:   start_o = base_i;
         2'b11:   start_o = base_i + STEP;
         2'b10:   start_o = base_i - span;
         default: start_o = base_i - span + STEP;
      endcase
   end

   assign final_o = up_i ? (base_i + span) : (base_i - span);

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int INSN_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LIST_W     = 16,
   parameter int WORD_BYTES = 4,
   parameter int POP_STYLE  = 1,
   localparam int IDX_W     = $clog2(LIST_W),
   localparam int CNT_W     = $clog2(LIST_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [INSN_W-1:0] insn_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              idle_o,
   output logic              bus_req_o,
   output logic              bus_we_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic              bus_ack_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic [IDX_W-1:0]  xfer_idx_o,
   input  logic [DATA_W-1:0] reg_rdata_i,
   output logic              reg_we_o,
   output logic [IDX_W-1:0]  reg_widx_o,
   output logic [DATA_W-1:0] reg_wdata_o,
   output logic              done_o,
   output logic              wb_en_o,
   output logic [RN_W-1:0]   wb_idx_o,
   output logic [ADDR_W-1:0] wb_value_o
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   // elaboration checks
   if (INSN_W <= FLD_BEFORE) begin : g_bad_insn
      $error("blkxfer_seq: INSN_W too narrow for the mode fields");
   end
   if (LIST_W < 2 || LIST_W > FLD_RN_LSB) begin : g_bad_list
      $error("blkxfer_seq: LIST_W must lie in 2..16");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("blkxfer_seq: ADDR_W too narrow");
   end

   // field decode
   logic              f_before, f_up, f_wback, f_load;
   logic [RN_W-1:0]   f_rn;
   logic [LIST_W-1:0] f_list;
   logic              insn_unused;

   assign f_before    = insn_i[FLD_BEFORE];
   assign f_up        = insn_i[FLD_UP];
   assign f_wback     = insn_i[FLD_WBACK];
   assign f_load      = insn_i[FLD_LOAD];
   assign f_rn        = insn_i[FLD_RN_LSB +: RN_W];
   assign f_list      = insn_i[LIST_W-1:0];
   assign insn_unused = ^insn_i;

   // count and address precompute
   logic [CNT_W-1:0]  sel_count;
   logic [ADDR_W-1:0] first_addr, end_base;

   blkxfer_popcount #(
      .LIST_W (LIST_W),
      .CNT_W  (CNT_W),
      .STYLE  (POP_STYLE)
   ) u_count (
      .bits_i  (f_list),
      .count_o (sel_count)
   );

   blkxfer_addrgen #(
      .ADDR_W     (ADDR_W),
      .CNT_W      (CNT_W),
      .WORD_BYTES (WORD_BYTES)
   ) u_addr (
      .base_i   (base_i),
      .count_i  (sel_count),
      .before_i (f_before),
      .up_i     (f_up),
      .start_o  (first_addr),
      .final_o  (end_base)
   );

   // state
   sq_state_e         state_q;
   logic [LIST_W-1:0] mask_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] final_q;
   logic              load_q;
   logic              wben_q;
   logic [RN_W-1:0]   rn_q;

   // next register from the remaining mask
   logic [IDX_W-1:0]  cur_idx;
   logic [LIST_W-1:0] cur_hot;
   logic [LIST_W-1:0] mask_nxt;
   logic              beat;

   blkxfer_lowest #(
      .LIST_W (LIST_W),
      .IDX_W  (IDX_W)
   ) u_pick (
      .mask_i   (mask_q),
      .idx_o    (cur_idx),
      .onehot_o (cur_hot)
   );

   assign mask_nxt = mask_q & ~cur_hot;
   assign beat     = (state_q == SQ_MOVE) && bus_ack_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         mask_q  <= '0;
         addr_q  <= '0;
         final_q <= '0;
         load_q  <= 1'b0;
         wben_q  <= 1'b0;
         rn_q    <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (start_i) begin
                  mask_q  <= f_list;
                  addr_q  <= first_addr;
                  final_q <= end_base;
                  load_q  <= f_load;
                  wben_q  <= f_wback;
                  rn_q    <= f_rn;
                  state_q <= (|f_list) ? SQ_MOVE : SQ_FIN;
               end
            end
            SQ_MOVE: begin
               if (bus_ack_i) begin
                  mask_q <= mask_nxt;
                  addr_q <= addr_q + STEP;
                  if (mask_nxt == '0) state_q <= SQ_FIN;
               end
            end
            SQ_FIN: begin
               state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // outputs
   assign idle_o      = (state_q == SQ_IDLE);
   assign bus_req_o   = (state_q == SQ_MOVE);
   assign bus_we_o    = bus_req_o && !load_q;
   assign bus_addr_o  = addr_q;
   assign bus_wdata_o = reg_rdata_i;
   assign xfer_idx_o  = cur_idx;

   assign reg_we_o    = beat && load_q;
   assign reg_widx_o  = cur_idx;
   assign reg_wdata_o = bus_rdata_i;

   assign done_o      = (state_q == SQ_FIN);
   assign wb_en_o     = done_o && wben_q;
   assign wb_idx_o    = rn_q;
   assign wb_value_o  = final_q;

endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 4,
   parameter int WORD_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              idle_o,
   input logic              bus_req_o,
   input logic              bus_we_o,
   input logic              bus_ack_i,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic [IDX_W-1:0]  xfer_idx_o,
   input logic              reg_we_o,
   input logic              done_o,
   input logic              wb_en_o
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   // R1: an idle sequencer shows no bus activity and no completion
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o |-> (!bus_req_o && !done_o && !reg_we_o));

   // R5: a pending request holds still
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)
                                     && $stable(xfer_idx_o) && $stable(bus_we_o)));

   // R4: after an accepted beat the next one is one word up and a higher register
   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_ack_i) |=> (!bus_req_o ||
         ((bus_addr_o == $past(bus_addr_o) + STEP) && (xfer_idx_o > $past(xfer_idx_o)))));

   // R7: after an accepted beat either another request or completion follows
   assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_ack_i) |=> (bus_req_o || done_o));

   // R7: completion is a single cycle and is followed by idle
   assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && idle_o));

   // R7: writeback enable only with completion
   assert_wben_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> done_o);

   // R6: register writes only on acknowledged reads
   assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we_o |-> (bus_req_o && bus_ack_i && !bus_we_o));

   // R9: a start seen while idle is taken
   assert_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && start_i) |=> !idle_o);

endmodule

bind blkxfer_seq blkxfer_chk #(
   .ADDR_W     (ADDR_W),
   .IDX_W      (IDX_W),
   .WORD_BYTES (WORD_BYTES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .idle_o     (idle_o),
   .bus_req_o  (bus_req_o),
   .bus_we_o   (bus_we_o),
   .bus_ack_i  (bus_ack_i),
   .bus_addr_o (bus_addr_o),
   .xfer_idx_o (xfer_idx_o),
   .reg_we_o   (reg_we_o),
   .done_o     (done_o),
   .wb_en_o    (wb_en_o)
);

// File: tb/blkxfer_seq_tb.sv
`timescale 1ns/1ps
module blkxfer_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] insn_i = '0;
   logic [31:0] base_i = '0;
   logic        idle_o, bus_req_o, bus_we_o;
   logic [31:0] bus_addr_o, bus_wdata_o;
   logic        bus_ack_i = 1'b0;
   logic [31:0] bus_rdata_i = '0;
   logic [3:0]  xfer_idx_o;
   logic [31:0] reg_rdata_i = '0;
   logic        reg_we_o;
   logic [3:0]  reg_widx_o;
   logic [31:0] reg_wdata_o;
   logic        done_o, wb_en_o;
   logic [3:0]  wb_idx_o;
   logic [31:0] wb_value_o;

   always #5 clk = ~clk;

   blkxfer_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i), .base_i(base_i),
      .idle_o(idle_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
      .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i),
      .bus_rdata_i(bus_rdata_i), .xfer_idx_o(xfer_idx_o), .reg_rdata_i(reg_rdata_i),
      .reg_we_o(reg_we_o), .reg_widx_o(reg_widx_o), .reg_wdata_o(reg_wdata_o),
      .done_o(done_o), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_value_o(wb_value_o)
   );

   typedef struct {
      logic [31:0] addr;
      logic [3:0]  idx;
      logic        we;
      logic [31:0] data;
      bit          first;
   } beat_t;

   typedef struct {
      logic        en;
      logic [3:0]  idx;
      logic [31:0] value;
   } fin_t;

   beat_t       xq[$];
   fin_t        dq[$];
   logic [31:0] mem [logic [31:0]];
   logic [31:0] regf [16];
   int          compared = 0;
   int          mismatched = 0;
   int          cyc = 0;
   int          done_cnt = 0;
   int          done_cyc = 0;
   int          ack_mode = 0;
   bit          finished = 0;

   function automatic logic [31:0] memrd(logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return a ^ 32'h5A5A_0F0F;
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // bus and register file responder
   always @(posedge clk) begin
      #1;
      bus_ack_i   <= (ack_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
      bus_rdata_i <= memrd(bus_addr_o);
      reg_rdata_i <= regf[xfer_idx_o];
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n && bus_req_o && bus_ack_i) begin
         if (xq.size() == 0) begin
            chk(0, "R4 unexpected access", bus_addr_o, 32'h0);
         end else begin
            beat_t e;
            e = xq.pop_front();
            chk(bus_addr_o == e.addr, e.first ? "R3 first address" : "R4 address step",
                bus_addr_o, e.addr);
            chk(xfer_idx_o == e.idx, "R4 register order", 32'(xfer_idx_o), 32'(e.idx));
            chk(bus_we_o == e.we, "R2 load/store direction", 32'(bus_we_o), 32'(e.we));
            if (e.we) begin
               chk(bus_wdata_o == e.data, "R6 store data", bus_wdata_o, e.data);
               chk(reg_we_o == 1'b0, "R6 no reg write on store", 32'(reg_we_o), 32'h0);
               mem[bus_addr_o] = bus_wdata_o;
            end else begin
               chk(reg_we_o == 1'b1, "R6 reg write strobe", 32'(reg_we_o), 32'h1);
               chk(reg_widx_o == e.idx, "R6 reg write index", 32'(reg_widx_o), 32'(e.idx));
               chk(reg_wdata_o == e.data, "R6 reg write data", reg_wdata_o, e.data);
               regf[reg_widx_o] = reg_wdata_o;
            end
         end
      end
      if (rst_n && done_o) begin
         if (dq.size() == 0) begin
            chk(0, "R9 unexpected completion", 32'h1, 32'h0);
         end else begin
            fin_t f;
            f = dq.pop_front();
            chk(wb_en_o == f.en, "R7 writeback enable", 32'(wb_en_o), 32'(f.en));
            chk(wb_idx_o == f.idx, "R2 base register number", 32'(wb_idx_o), 32'(f.idx));
            chk(wb_value_o == f.value, "R7 final base", wb_value_o, f.value);
         end
         done_cyc = cyc;
         done_cnt++;
      end
   end

   // driver: one instruction
   task automatic run(bit pre, bit up, bit wb, bit ld, logic [3:0] rn,
                      logic [15:0] list, logic [31:0] base, bit poke);
      int          n = 0;
      int          c0;
      int          target;
      logic [31:0] a;
      for (int i = 0; i < 16; i++) if (list[i]) n++;
      case ({pre, up})
         2'b01:   a = base;
         2'b11:   a = base + 32'd4;
         2'b10:   a = base - 32'(4 * n);
         default: a = base - 32'(4 * n) + 32'd4;
      endcase
      for (int i = 0; i < 16; i++) begin
         if (list[i]) begin
            beat_t e;
            e.addr  = a;
            e.idx   = 4'(i);
            e.we    = !ld;
            e.data  = ld ? memrd(a) : regf[i];
            e.first = (xq.size() == 0);
            xq.push_back(e);
            a = a + 32'd4;
         end
      end
      begin
         fin_t f;
         f.en    = wb;
         f.idx   = rn;
         f.value = up ? base + 32'(4 * n) : base - 32'(4 * n);
         dq.push_back(f);
      end
      @(negedge clk);
      while (!idle_o) @(negedge clk);
      insn_i  = {4'hE, 3'b100, pre, up, 1'b0, wb, ld, rn, list};
      base_i  = base;
      start_i = 1'b1;
      c0      = cyc;
      target  = done_cnt + 1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) begin
         // R9: start while busy must be ignored
         insn_i  = {4'hE, 3'b100, ~pre, ~up, 1'b0, 1'b1, ~ld, ~rn, ~list};
         base_i  = ~base;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      wait (done_cnt >= target);
      if (ack_mode == 0)
         chk(done_cyc == c0 + 1 + n, n == 0 ? "R8 empty list timing" : "R10 one beat per cycle",
             32'(done_cyc - c0), 32'(1 + n));
      @(negedge clk);
      chk(xq.size() == 0, "R4 all selected registers moved", 32'(xq.size()), 32'h0);
      chk(idle_o == 1'b1, "R7 idle after completion", 32'(idle_o), 32'h1);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog expired before the test sequence ended");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) regf[i] = 32'hC0DE_0000 | (32'(i) * 32'h0001_1011);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(idle_o == 1'b1, "R1 idle in reset", 32'(idle_o), 32'h1);
      chk(bus_req_o == 1'b0, "R1 no request in reset", 32'(bus_req_o), 32'h0);
      chk(done_o == 1'b0, "R1 no done in reset", 32'(done_o), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(idle_o == 1'b1 && !bus_req_o && !done_o && !wb_en_o && !reg_we_o,
          "R1 quiet after reset", {27'h0, idle_o, bus_req_o, done_o, wb_en_o, reg_we_o},
          32'h10);

      // R3, R4, R6: all four modes, store then load back
      ack_mode = 0;
      for (int m = 0; m < 4; m++) begin
         run(m[1], m[0], 1'b1, 1'b0, 4'(m + 3), 16'h8421, 32'h0000_4000 + 32'(m * 32'h100), 1'b0);
         run(m[1], m[0], 1'b0, 1'b1, 4'(m + 3), 16'h8421, 32'h0000_4000 + 32'(m * 32'h100), 1'b0);
      end
      // R8: empty list, each mode, writeback requested
      for (int m = 0; m < 4; m++) run(m[1], m[0], 1'b1, 1'b0, 4'd13, 16'h0000, 32'h0001_0000, 1'b0);
      // boundary lists
      run(1'b0, 1'b1, 1'b1, 1'b0, 4'd1, 16'hFFFF, 32'h0000_8000, 1'b0);
      run(1'b1, 1'b0, 1'b1, 1'b1, 4'd2, 16'hFFFF, 32'h0000_8040, 1'b0);
      run(1'b1, 1'b1, 1'b0, 1'b0, 4'd15, 16'h0001, 32'hFFFF_FFFC, 1'b0);
      run(1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 16'h8000, 32'h0000_0000, 1'b0);
      // R9: start pulses while busy
      run(1'b0, 1'b1, 1'b1, 1'b0, 4'd6, 16'h0F0F, 32'h0002_0000, 1'b1);
      run(1'b1, 1'b0, 1'b0, 1'b1, 4'd6, 16'h0101, 32'h0002_0020, 1'b1);
      // random lists with stalled bus
      ack_mode = 1;
      for (int k = 0; k < 60; k++) begin
         logic [15:0] lst;
         lst = 16'($urandom);
         if (k % 3 == 0) lst = lst & 16'($urandom);
         run(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
             lst, 32'h0003_0000 + (32'($urandom_range(0, 255)) << 2), (k % 7) == 0);
      end
      // random lists with bus always ready
      ack_mode = 0;
      for (int k = 0; k < 30; k++) begin
         run(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
             16'($urandom), 32'($urandom) & 32'hFFFF_FFFC, 1'b0);
      end
      repeat (3) @(negedge clk);
      chk(dq.size() == 0, "R7 every completion seen", 32'(dq.size()), 32'h0);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule